// File: doc/BRIEF.md
# Fused Multiply-Add Addend Alignment Shifter

For an operation f = A*C + B, this block takes the three biased exponents and the significand of the addend B, works out how far B must be moved relative to the product, and delivers B positioned inside a 188-bit dataflow. The low 128 bits of that dataflow hold the product. Above them sit 60 further bits: a 5-bit gap, then the 53-bit addend slot, then two vacant bits. Exponents are 13-bit values with a bias of 0x0FFF. Product generation, the wide add and normalization belong to neighbouring blocks.

The aligner only shifts right. The addend starts at its leftmost placement, just above the gap, and moves right by the computed amount. If B dominates the product, B stays at that leftmost placement and a flag reports this. If the shift would carry B entirely past the right end, the output is forced to a constant. A further fixed offset is folded into the internal shift amount so that every legal alignment is a positive right shift. The shift itself is done in two registered steps: a coarse step in multiples of 16 bits, then a fine step.

When the operation is an effective subtract, the addend enters the adder complemented. The whole 188-bit output, including the fill bits, is then the bitwise inverse of the add-case output. Bits of the addend that fall below bit 0 are collected into a sticky bit.

Top module: `fma_addend_align`

## Requirements
- R1: Let SA0 = expA + expC - expB - 0x0FFF + 59, using the adjusted exponents of R6. For 0 <= SA0 < 186 the output is the 53-bit significand with its LSB at bit 133 (bits 133..185), shifted right by SA0 bits. The flags `out_bmgtp` and `out_oor` are both 0.
- R2: If SA0 < 0, `out_bmgtp` is 1 and the significand sits unshifted at bits 133..185. All other bits are fill and `out_sticky` is 0.
- R3: If SA0 >= 186, `out_oor` is 1. The data is all zeros for an add and all ones for an effective subtract, and `out_sticky` is the OR of all 53 significand bits.
- R4: With `eff_sub` = 1, all 188 output bits are the bitwise complement of the result the same operands give with `eff_sub` = 0. The flags and the sticky bit do not change.
- R5: In the shift case, `out_sticky` is the OR of the significand bits shifted below bit 0.
- R6: An operand whose implied bit is 0 has its exponent bit 0 forced to 1 before SA0 is formed. The implied bits are `a_implied`, `c_implied` and bit 52 of `b_sig`.
- R7: `out_valid` follows `in_valid` exactly three clock edges later. A new operand set is accepted on every cycle.
- R8: While `rst` is high and on the first cycles after it falls, `out_valid` is 0.
- R9: `out_bmgtp` and `out_oor` are never both 1. In an add, the two vacant bits 186..187 are always 0; in an effective subtract they are always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present this cycle |
| exp_a | input | 13 | Biased exponent of multiplicand A |
| exp_c | input | 13 | Biased exponent of multiplier C |
| exp_b | input | 13 | Biased exponent of addend B |
| a_implied | input | 1 | Implied significand bit of A |
| c_implied | input | 1 | Implied significand bit of C |
| b_sig | input | 53 | Addend significand, bit 52 is the implied bit |
| eff_sub | input | 1 | Effective subtract: complement the addend |
| out_valid | output | 1 | Aligned result present |
| out_aligned | output | 188 | Addend positioned in the dataflow |
| out_sticky | output | 1 | OR of addend bits shifted past bit 0 |
| out_bmgtp | output | 1 | Addend much greater than product, unshifted |
| out_oor | output | 1 | Shift beyond the dataflow, output forced |

## Verification
The properties assume that `in_valid` is driven to a known level in every cycle, including during reset. They also assume that the fill bits around the addend follow `eff_sub` alone, so any region the addend cannot reach is uniformly zero or uniformly one. The bench holds every exponent inside the 13-bit range. It picks expA and expC near the middle of that range and derives expB from a target SA0, so the intended shift amount is never disturbed by wraparound. Targets are swept across the negative region, the coarse-step boundaries at multiples of 16, the last legal shift of 185 and the first out-of-range value of 186, and random values in between.

// File: rtl/fma_align_pkg.sv
package fma_align_pkg;

    // Placement class decided in the first stage and carried down the pipe
    typedef enum logic [1:0] {
        PL_SHIFT = 2'd0,   // normal right shift
        PL_BIG   = 2'd1,   // addend dominates, keep leftmost placement
        PL_OOR   = 2'd2    // shifted past the dataflow, force constant
    } place_e;

endpackage

// File: rtl/fma_align_sa.sv
module fma_align_sa
    import fma_align_pkg::*;
#(
    parameter int EXP_W  = 13,
    parameter int BIAS   = 'h0FFF,
    parameter int OFF0   = 59,
    parameter int OSL    = 64,
    parameter int SH_LIM = 250,
    parameter int SHW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             v_in,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_c,
    input  logic [EXP_W-1:0] exp_b,
    input  logic             a_implied,
    input  logic             c_implied,
    input  logic             b_implied,
    output logic             v_q,
    output place_e           place_q,
    output logic [SHW-1:0]   sh_q
);
    localparam int SAW = EXP_W + 3;
    localparam logic signed [SAW-1:0] K_S   = SAW'(OSL + OFF0 - BIAS);
    localparam logic signed [SAW-1:0] OSL_S = SAW'(OSL);
    localparam logic signed [SAW-1:0] LIM_S = SAW'(SH_LIM);

    logic [EXP_W-1:0]      ea_f, ec_f, eb_f;
    logic signed [SAW-1:0] sa;
    place_e                place_n;

    // Denormal operands: exponent LSB forced high to keep the bias consistent
    always_comb begin
        ea_f = {exp_a[EXP_W-1:1], exp_a[0] | ~a_implied};
        ec_f = {exp_c[EXP_W-1:1], exp_c[0] | ~c_implied};
        eb_f = {exp_b[EXP_W-1:1], exp_b[0] | ~b_implied};
        sa   = $signed({{(SAW-EXP_W){1'b0}}, ea_f})
             + $signed({{(SAW-EXP_W){1'b0}}, ec_f})
             - $signed({{(SAW-EXP_W){1'b0}}, eb_f})
             + K_S;
        if (sa < OSL_S)
            place_n = PL_BIG;
        else if (sa >= LIM_S)
            place_n = PL_OOR;
        else
            place_n = PL_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q     <= 1'b0;
            place_q <= PL_SHIFT;
            sh_q    <= '0;
        end else begin
            v_q     <= v_in;
            place_q <= place_n;
            sh_q    <= sa[SHW-1:0];
        end
    end

endmodule

// File: rtl/fma_align_coarse.sv
module fma_align_coarse
    import fma_align_pkg::*;
#(
    parameter int XW  = 252,
    parameter int SHW = 8,
    parameter int CB  = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           v_in,
    input  logic [XW-1:0]  vec_in,
    input  logic [SHW-1:0] sh_in,
    input  place_e         place_in,
    output logic           v_q,
    output logic [XW-1:0]  vec_q,
    output logic [CB-1:0]  fine_q,
    output logic           stk_q,
    output place_e         place_q
);
    logic [SHW-1:0] camt;
    logic [XW-1:0]  shifted;
    logic           lost;

    // Coarse step: move by whole multiples of the coarse granule
    always_comb begin
        camt    = {sh_in[SHW-1:CB], {CB{1'b0}}};
        shifted = vec_in >> camt;
        lost    = |(vec_in & ~({XW{1'b1}} << camt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q     <= 1'b0;
            vec_q   <= '0;
            fine_q  <= '0;
            stk_q   <= 1'b0;
            place_q <= PL_SHIFT;
        end else begin
            v_q     <= v_in;
            vec_q   <= shifted;
            fine_q  <= sh_in[CB-1:0];
            stk_q   <= lost;
            place_q <= place_in;
        end
    end

endmodule

// File: rtl/fma_align_fine.sv
module fma_align_fine #(
    parameter int XW   = 252,
    parameter int DF_W = 188,
    parameter int CB   = 4
) (
    input  logic [XW-1:0]   vec_in,
    input  logic [CB-1:0]   fine_in,
    output logic [DF_W-1:0] aligned,
    output logic            stk
);
    // Fine step: residual shift below the coarse granule
    always_comb begin
        aligned = DF_W'(vec_in >> fine_in);
        stk     = |(vec_in & ~({XW{1'b1}} << fine_in));
    end

endmodule

// File: rtl/fma_addend_align.sv
module fma_addend_align
    import fma_align_pkg::*;
#(
    parameter int EXP_W  = 13,
    parameter int SIG_W  = 53,
    parameter int PROD_W = 128,
    parameter int GAP    = 5,
    parameter int LEFT_W = 60,
    parameter int OSL    = 64,
    parameter int COARSE = 16,
    parameter int BIAS   = 'h0FFF,
    parameter int OFF0   = 59
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [EXP_W-1:0]            exp_a,
    input  logic [EXP_W-1:0]            exp_c,
    input  logic [EXP_W-1:0]            exp_b,
    input  logic                        a_implied,
    input  logic                        c_implied,
    input  logic [SIG_W-1:0]            b_sig,
    input  logic                        eff_sub,
    output logic                        out_valid,
    output logic [LEFT_W+PROD_W-1:0]    out_aligned,
    output logic                        out_sticky,
    output logic                        out_bmgtp,
    output logic                        out_oor
);
    localparam int DF_W     = LEFT_W + PROD_W;
    localparam int ADD_LSB0 = PROD_W + GAP;        // addend LSB, unshifted
    localparam int ADD_END  = ADD_LSB0 + SIG_W;    // first vacant bit
    localparam int XW       = DF_W + OSL;          // window incl. left offset
    localparam int SH_LIM   = OSL + ADD_END;       // first out-of-range SA
    localparam int SHW      = $clog2(SH_LIM);
    localparam int CB       = $clog2(COARSE);

    // Stage 1: shift amount and placement class
    logic           v1;
    place_e         place1;
    logic [SHW-1:0] sh1;
    logic [SIG_W-1:0] sig1;
    logic           sub1;

    fma_align_sa #(
        .EXP_W(EXP_W), .BIAS(BIAS), .OFF0(OFF0), .OSL(OSL),
        .SH_LIM(SH_LIM), .SHW(SHW)
    ) u_sa (
        .clk(clk), .rst(rst), .v_in(in_valid),
        .exp_a(exp_a), .exp_c(exp_c), .exp_b(exp_b),
        .a_implied(a_implied), .c_implied(c_implied),
        .b_implied(b_sig[SIG_W-1]),
        .v_q(v1), .place_q(place1), .sh_q(sh1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sig1 <= '0;
            sub1 <= 1'b0;
        end else begin
            sig1 <= b_sig;
            sub1 <= eff_sub;
        end
    end

    // Stage 2: coarse shift of the addend from its offset start position
    logic [XW-1:0]    vec1;
    logic             v2;
    logic [XW-1:0]    vec2;
    logic [CB-1:0]    fine2;
    logic             stk2;
    place_e           place2;
    logic [SIG_W-1:0] sig2;
    logic             sub2;

    assign vec1 = XW'(sig1) << (ADD_LSB0 + OSL);

    fma_align_coarse #(.XW(XW), .SHW(SHW), .CB(CB)) u_coarse (
        .clk(clk), .rst(rst), .v_in(v1), .vec_in(vec1), .sh_in(sh1),
        .place_in(place1), .v_q(v2), .vec_q(vec2), .fine_q(fine2),
        .stk_q(stk2), .place_q(place2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sig2 <= '0;
            sub2 <= 1'b0;
        end else begin
            sig2 <= sig1;
            sub2 <= sub1;
        end
    end

    // Stage 3: fine shift, placement select, complement, output register
    logic [DF_W-1:0] fine_al;
    logic            fine_stk;
    logic [DF_W-1:0] al_n;
    logic            stk_n;

    fma_align_fine #(.XW(XW), .DF_W(DF_W), .CB(CB)) u_fine (
        .vec_in(vec2), .fine_in(fine2), .aligned(fine_al), .stk(fine_stk)
    );

    always_comb begin
        unique case (place2)
            PL_BIG: begin
                al_n  = DF_W'(sig2) << ADD_LSB0;
                stk_n = 1'b0;
            end
            PL_OOR: begin
                al_n  = '0;
                stk_n = |sig2;
            end
            default: begin
                al_n  = fine_al;
                stk_n = stk2 | fine_stk;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_aligned <= '0;
            out_sticky  <= 1'b0;
            out_bmgtp   <= 1'b0;
            out_oor     <= 1'b0;
        end else begin
            out_valid   <= v2;
            out_aligned <= al_n ^ {DF_W{sub2}};
            out_sticky  <= stk_n;
            out_bmgtp   <= (place2 == PL_BIG);
            out_oor     <= (place2 == PL_OOR);
        end
    end

endmodule

// File: rtl/fma_addend_align_chk.sv
module fma_addend_align_chk #(
    parameter int DF_W     = 188,
    parameter int ADD_LSB0 = 133,
    parameter int ADD_END  = 186
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            out_valid,
    input logic [DF_W-1:0] out_aligned,
    input logic            out_sticky,
    input logic            out_bmgtp,
    input logic            out_oor
);
    logic [2:0] vpipe;

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[1:0], in_valid};
    end

    // R7
    latency_three_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vpipe[2]);

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_bmgtp && out_oor));

    // R3
    oor_constant_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_oor) |-> (out_aligned == '0 || out_aligned == '1));

    // R2
    big_no_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bmgtp) |-> !out_sticky);

    // R2
    big_low_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bmgtp) |->
        (out_aligned[ADD_LSB0-1:0] == '0 || out_aligned[ADD_LSB0-1:0] == '1));

    // R9
    vacant_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |->
        (out_aligned[DF_W-1:ADD_END] == '0 || out_aligned[DF_W-1:ADD_END] == '1));

endmodule

bind fma_addend_align fma_addend_align_chk #(
    .DF_W(DF_W), .ADD_LSB0(ADD_LSB0), .ADD_END(ADD_END)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_aligned(out_aligned), .out_sticky(out_sticky),
    .out_bmgtp(out_bmgtp), .out_oor(out_oor)
);

// File: tb/fma_addend_align_test.sv
module fma_addend_align_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 188;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [12:0]   exp_a = '0, exp_c = '0, exp_b = '0;
    logic          a_implied = 1'b1, c_implied = 1'b1;
    logic [52:0]   b_sig = '0;
    logic          eff_sub = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_aligned;
    logic          out_sticky, out_bmgtp, out_oor;

    fma_addend_align uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .exp_a(exp_a), .exp_c(exp_c), .exp_b(exp_b),
        .a_implied(a_implied), .c_implied(c_implied),
        .b_sig(b_sig), .eff_sub(eff_sub),
        .out_valid(out_valid), .out_aligned(out_aligned),
        .out_sticky(out_sticky), .out_bmgtp(out_bmgtp), .out_oor(out_oor)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [DW-1:0] al;
        logic          stk;
        logic          bmg;
        logic          oor;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    q_cyc[$];
    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    bit    done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Driver: applies one operand set and pushes its expected result
    task automatic drive(input int ea, input int ec, input int eb,
                         input bit ai, input bit ci,
                         input logic [52:0] sig, input bit sub);
        int eaf, ecf, ebf, sa0;
        exp_t e;
        logic [511:0] big;
        string tag;
        eaf = ai ? ea : (ea | 1);                       // R6
        ecf = ci ? ec : (ec | 1);
        ebf = sig[52] ? eb : (eb | 1);
        sa0 = eaf + ecf - ebf - 4095 + 59;
        e = '0;
        if (sa0 < 0) begin
            e.bmg = 1'b1;
            e.al  = DW'(sig) << 133;
            tag   = "R2";
        end else if (sa0 >= 186) begin
            e.oor = 1'b1;
            e.stk = |sig;
            tag   = "R3";
        end else begin
            big   = 512'(sig) << (133 + 256);
            big   = big >> sa0;
            e.al  = big[256+DW-1:256];
            e.stk = |big[255:0];                        // R5
            tag   = (ai && ci && sig[52]) ? "R1" : "R6";
        end
        if (sub) begin
            e.al = ~e.al;                               // R4
            tag  = {tag, "/R4"};
        end
        @(negedge clk);
        exp_a = 13'(ea); exp_c = 13'(ec); exp_b = 13'(eb);
        a_implied = ai; c_implied = ci; b_sig = sig; eff_sub = sub;
        in_valid = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        q_cyc.push_back(cyc);
    endtask

    // Target SA0 with normal operands
    task automatic drive_sa(input int sa0, input logic [52:0] sig, input bit sub);
        drive(3000, 3000, 1964 - sa0, 1'b1, 1'b1, sig, sub);
    endtask

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R7", "unexpected out_valid", DW'(1), DW'(0));
            end else begin
                exp_t  e;
                string t;
                int    c;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                c = q_cyc.pop_front();
                check(cyc - c == 3, "R7", "latency", DW'(cyc - c), DW'(3));
                check(out_aligned == e.al, t, "aligned", out_aligned, e.al);
                check(out_sticky == e.stk, "R5", "sticky", DW'(out_sticky), DW'(e.stk));
                check(out_bmgtp == e.bmg, "R2", "bmgtp", DW'(out_bmgtp), DW'(e.bmg));
                check(out_oor == e.oor, "R3", "oor", DW'(out_oor), DW'(e.oor));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired pending=%0d", q_exp.size());
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [52:0] s1, s2;
        s1 = {1'b1, 52'h5A5A5_1234_9ABC};
        s2 = {1'b1, 51'h0, 1'b1};
        // R8: activity on in_valid during reset must not emerge
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "valid in reset", DW'(out_valid), DW'(0));
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "valid after reset", DW'(out_valid), DW'(0));
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "valid after reset+1", DW'(out_valid), DW'(0));

        // R1 shift case: coarse boundaries and extremes
        drive_sa(0, s1, 1'b0);
        drive_sa(1, s1, 1'b0);
        drive_sa(15, s1, 1'b0);
        drive_sa(16, s1, 1'b0);
        drive_sa(17, s2, 1'b0);
        drive_sa(59, s1, 1'b0);
        drive_sa(133, s1, 1'b0);
        drive_sa(160, s2, 1'b0);
        drive_sa(185, s1, 1'b0);
        drive_sa(185, {1'b1, 52'h0}, 1'b0);
        // R2 addend dominates
        drive_sa(-1, s1, 1'b0);
        drive_sa(-50, s2, 1'b0);
        drive_sa(-1900, s1, 1'b1);
        // R3 out of range, both fills
        drive_sa(186, s1, 1'b0);
        drive_sa(187, s1, 1'b1);
        drive_sa(1000, s2, 1'b0);
        drive(3000, 3000, 1964 - 300, 1'b1, 1'b1, 53'h0, 1'b0);
        // R4 effective subtract in the shift case
        drive_sa(0, s1, 1'b1);
        drive_sa(70, s1, 1'b1);
        drive_sa(180, s2, 1'b1);
        // R6 denormal exponent LSB forcing
        drive(3000, 3000, 1964 - 40, 1'b0, 1'b1, s1, 1'b0);
        drive(3000, 3000, 1964 - 40, 1'b1, 1'b0, s1, 1'b0);
        drive(3000, 3000, 1964, 1'b1, 1'b1, {1'b0, 52'hF_0000_0000_00FF}, 1'b0);
        drive(3000, 3000, 1964 + 1, 1'b0, 1'b0, {1'b0, 52'h1}, 1'b1);
        // Random back-to-back stream
        for (int i = 0; i < 400; i++) begin
            int ea, ec, sa;
            logic [63:0] r;
            ea = 2500 + int'($urandom_range(0, 500));
            ec = 2500 + int'($urandom_range(0, 500));
            sa = int'($urandom_range(0, 230)) - 20;
            r  = {$urandom, $urandom};
            drive(ea, ec, ea + ec - 4036 - sa, 1'($urandom), 1'($urandom),
                  r[52:0] | {($urandom_range(0, 3) != 0), 52'h0}, 1'($urandom));
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (q_exp.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "valid drained", DW'(out_valid), DW'(0));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule